// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is a serial slave that lets a host read and write a bank of 64 eight-bit registers over a chip-select, serial-clock, data-in, data-out link. Each transfer opens with a command byte and continues with any number of data bytes. The command byte selects the direction and the starting register. It also selects whether the register pointer steps forward after every data byte or stays on the same register.

The serial pins are oversampled by a fast system clock. Chip select, serial clock and data-in pass through a synchronizer, and the serial clock edges are recovered as single-cycle events. One register sits at a fixed address and always returns a constant identity byte. One bit of another register switches read data from the dedicated data-out pin onto the shared data-in pin, which gives a 3-wire bidirectional link. The pad drivers sit outside the block, so every output pin comes with a separate enable.

Top module: `spi_reg_slave`

## Requirements
- R1: The first byte of a transfer is the command byte, received MSB first. Its first bit selects the direction (1 = read, 0 = write), its second bit is the step flag, and its last six bits are the register address, MSB first.
- R2: A write of one register takes 16 serial clock pulses and stores the data byte at the commanded address. A read returns that register's value MSB first. The slave launches each bit on a falling serial clock edge, and the host samples it on the next rising edge (the clock idles high).
- R3: With the step flag at 1, the address advances by one after every data byte in either direction, and it wraps from 3Fh to 00h.
- R4: With the step flag at 0, every data byte of a burst uses the commanded address. In a write burst the last byte is the one kept, and a read burst returns the same value repeatedly. Neighbouring registers are left unchanged.
- R5: Register 0Fh always reads 33h, and writes to it are discarded.
- R6: The output enables are low whenever chip select (active low) is high, during the command byte and during write data. The active pin's enable is high for every bit of read data.
- R7: When bit 0 of register 23h is 1, read data is driven on `sdi_drv` with `sdi_oe` high and `sdo_oe` held low. When the bit is 0, read data uses `sdo`/`sdo_oe` and `sdi_oe` stays low.
- R8: Raising chip select in the middle of a transfer ends it. A data byte that is not complete is not written, and the next transfer starts with a fresh command byte.
- R9: After reset every register reads 00h except the identity register, and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in (value seen on the shared pin) |
| sdi_drv | output | 1 | Read data for the shared pin in 3-wire mode |
| sdi_oe | output | 1 | Drive enable for the shared pin |
| sdo | output | 1 | Read data on the dedicated output pin |
| sdo_oe | output | 1 | Drive enable for the dedicated output pin |

## Verification
Each serial edge is seen by the slave SYNC_STAGES cycles after it occurs. A read bit therefore appears SYNC_STAGES+1 system clocks after its falling serial edge, and a written byte lands SYNC_STAGES+1 clocks after the eighth rising edge of that byte. Both enables drop SYNC_STAGES clocks after chip select rises. The bench holds every serial half period for six system clocks and samples pins and enables just before each rising edge, well after the result is due. Stored contents are confirmed only by later read transfers, and a bench-side register model supplies the expected values.

// File: rtl/spi_reg_slave_pkg.sv
package spi_reg_slave_pkg;
   // transfer phase of the protocol engine
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CMD  = 2'd1,
      PH_DATA = 2'd2
   } xfer_phase_e;

   // number of flag bits ahead of the address in the command byte
   localparam int CMD_FLAG_BITS = 2;
endpackage

// File: rtl/spi_reg_slave_sync.sv
module spi_reg_slave_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = STAGES * W;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_reg_slave_sync: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[CHAIN_W-W-1:0], d};
   end

   assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/spi_reg_slave_front.sv
module spi_reg_slave_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   output logic cs_idle,
   output logic rise_evt,
   output logic fall_evt,
   output logic sdi_s
);
   logic sclk_s;
   logic sclk_q;

   // pins synchronised as one group so their relative order is kept
   spi_reg_slave_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     ({cs_idle, sclk_s, sdi_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b1;
      else        sclk_q <= sclk_s;
   end

   assign rise_evt = !cs_idle &&  sclk_s && !sclk_q;
   assign fall_evt = !cs_idle && !sclk_s &&  sclk_q;
endmodule

// File: rtl/spi_reg_slave_frame.sv
module spi_reg_slave_frame
   import spi_reg_slave_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_idle,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              tx_bit,
   output logic              tx_oe,
   output logic              in_data,
   output logic              is_read
);
   localparam int BIT_W = $clog2(DATA_W);
   localparam int LAST  = DATA_W - 1;

   xfer_phase_e       phase_q;
   logic [BIT_W-1:0]  bit_cnt_q;
   logic [DATA_W-2:0] rx_q;
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] full_byte;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;
   logic              step_q;
   logic              live_q;
   logic              byte_end;

   assign full_byte = {rx_q, sdi_s};
   assign byte_end  = rise_evt && (bit_cnt_q == BIT_W'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         bit_cnt_q <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         addr_q    <= '0;
         rd_q      <= 1'b0;
         step_q    <= 1'b0;
         live_q    <= 1'b0;
      end else if (cs_idle) begin
         phase_q   <= PH_IDLE;
         bit_cnt_q <= '0;
         live_q    <= 1'b0;
      end else begin
         if (phase_q == PH_IDLE) phase_q <= PH_CMD;
         if (rise_evt) begin
            rx_q      <= full_byte[DATA_W-2:0];
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (byte_end) begin
               if (phase_q != PH_DATA) begin
                  rd_q    <= full_byte[DATA_W-1];
                  step_q  <= full_byte[DATA_W-2];
                  addr_q  <= full_byte[ADDR_W-1:0];
                  phase_q <= PH_DATA;
               end else if (step_q) begin
                  addr_q  <= addr_q + 1'b1;
               end
            end
         end
         if (fall_evt && phase_q == PH_DATA && rd_q) begin
            if (bit_cnt_q == '0) begin
               tx_q   <= rd_data;
               live_q <= 1'b1;
            end else begin
               tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign wr_en    = byte_end && phase_q == PH_DATA && !rd_q;
   assign wr_data  = full_byte;
   assign cur_addr = addr_q;
   assign tx_bit   = tx_q[DATA_W-1];
   assign in_data  = (phase_q == PH_DATA);
   assign is_read  = rd_q;
   assign tx_oe    = live_q && rd_q && phase_q == PH_DATA && !cs_idle;
endmodule

// File: rtl/spi_reg_slave_bank.sv
module spi_reg_slave_bank #(
   parameter int                ADDR_W    = 6,
   parameter int                DATA_W    = 8,
   parameter int                ID_ADDR   = 15,
   parameter logic [DATA_W-1:0] ID_VALUE  = 8'h33,
   parameter int                MODE_ADDR = 35,
   parameter int                MODE_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              mode_bit
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] ID_SEL   = ADDR_W'(ID_ADDR);
   localparam logic [ADDR_W-1:0] MODE_SEL = ADDR_W'(MODE_ADDR);

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (wr_en && wr_addr != ID_SEL) begin
         store[wr_addr] <= wr_data;
      end
   end

   assign rd_data  = (rd_addr == ID_SEL) ? ID_VALUE : store[rd_addr];
   assign mode_bit = store[MODE_SEL][MODE_BIT];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
   parameter int                ADDR_W        = 6,
   parameter int                DATA_W        = 8,
   parameter int                SYNC_STAGES   = 2,
   parameter int                ID_ADDR       = 15,
   parameter logic [DATA_W-1:0] ID_VALUE      = 8'h33,
   parameter int                MODE_ADDR     = 35,
   parameter int                MODE_BIT      = 0,
   parameter bit                THREE_WIRE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   output logic sdi_drv,
   output logic sdi_oe,
   output logic sdo,
   output logic sdo_oe
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DATA_W != ADDR_W + spi_reg_slave_pkg::CMD_FLAG_BITS) begin : g_bad_width
      $error("spi_reg_slave: DATA_W must equal ADDR_W plus the two flag bits");
   end
   if ((1 << $clog2(DATA_W)) != DATA_W) begin : g_bad_pow2
      $error("spi_reg_slave: DATA_W must be a power of two");
   end
   if (ID_ADDR >= DEPTH || MODE_ADDR >= DEPTH || ID_ADDR == MODE_ADDR) begin : g_bad_addr
      $error("spi_reg_slave: identity and mode addresses must be distinct and in range");
   end
   if (MODE_BIT >= DATA_W) begin : g_bad_bit
      $error("spi_reg_slave: MODE_BIT out of range");
   end

   logic              cs_idle;
   logic              rise_evt;
   logic              fall_evt;
   logic              sdi_s;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] rd_data;
   logic              tx_bit;
   logic              tx_oe;
   logic              in_data;
   logic              is_read;
   logic              mode_bit;
   logic              three_wire;

   spi_reg_slave_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .cs_idle  (cs_idle),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .sdi_s    (sdi_s)
   );

   spi_reg_slave_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_idle  (cs_idle),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .sdi_s    (sdi_s),
      .rd_data  (rd_data),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cur_addr (cur_addr),
      .tx_bit   (tx_bit),
      .tx_oe    (tx_oe),
      .in_data  (in_data),
      .is_read  (is_read)
   );

   spi_reg_slave_bank #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ID_ADDR   (ID_ADDR),
      .ID_VALUE  (ID_VALUE),
      .MODE_ADDR (MODE_ADDR),
      .MODE_BIT  (MODE_BIT)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (cur_addr),
      .wr_data  (wr_data),
      .rd_addr  (cur_addr),
      .rd_data  (rd_data),
      .mode_bit (mode_bit)
   );

   if (THREE_WIRE_EN) begin : g_three_wire
      assign three_wire = mode_bit;
   end else begin : g_four_wire_only
      assign three_wire = 1'b0;
   end

   assign sdo_oe  = tx_oe && !three_wire;
   assign sdi_oe  = tx_oe &&  three_wire;
   assign sdo     = sdo_oe && tx_bit;
   assign sdi_drv = sdi_oe && tx_bit;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_idle,
   input logic              rise_evt,
   input logic              fall_evt,
   input logic              wr_en,
   input logic              in_data,
   input logic              is_read,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              sdo_oe,
   input logic              sdi_oe
);
   // R6
   cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |-> (!sdo_oe && !sdi_oe));

   // R6
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !is_read) |-> (!sdo_oe && !sdi_oe));

   // R2
   launch_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe || sdi_oe) |-> $past(fall_evt));

   // R2
   single_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_evt |=> $stable(cur_addr));

   // R8
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> !in_data);

   // R9
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!sdo_oe && !sdi_oe));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_idle  (cs_idle),
   .rise_evt (rise_evt),
   .fall_evt (fall_evt),
   .wr_en    (wr_en),
   .in_data  (in_data),
   .is_read  (is_read),
   .cur_addr (cur_addr),
   .sdo_oe   (sdo_oe),
   .sdi_oe   (sdi_oe)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;

   logic clk = 1'b0;
   logic rst_n, cs_n, sclk, sdi;
   logic sdi_drv, sdi_oe, sdo, sdo_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_reg_slave u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .sclk    (sclk),
      .sdi     (sdi),
      .sdi_drv (sdi_drv),
      .sdi_oe  (sdi_oe),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe)
   );

   int   checks = 0;
   int   fails  = 0;
   bit   finished = 1'b0;
   int   oe_err;
   logic [7:0] model [64];
   logic [7:0] wbuf  [8];
   logic [7:0] rbuf  [8];

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [5:0] step_addr(input logic [5:0] a, input logic inc, input int j);
      return inc ? 6'(int'(a) + j) : a;
   endfunction

   // one transfer; cut > 0 raises chip select after that many bits
   task automatic xfer(input logic rw, input logic inc, input logic [5:0] addr,
                       input int nbytes, input int cut);
      logic [7:0] cmd;
      int total;
      bit tw;
      cmd   = {rw, inc, addr};
      tw    = model[35][0];
      total = (cut > 0) ? cut : 8 * (nbytes + 1);
      oe_err = 0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int b = 0; b < total; b++) begin
         int k;
         int p;
         k = b / 8;
         p = 7 - (b % 8);
         sclk = 1'b0;
         if (k == 0)   sdi = cmd[p];
         else if (!rw) sdi = wbuf[k-1][p];
         else          sdi = 1'b0;
         repeat (HALF) @(negedge clk);
         if (k > 0 && rw) begin
            rbuf[k-1][p] = tw ? sdi_drv : sdo;
            if (sdi_oe !== tw || sdo_oe !== !tw) oe_err++;
         end else if (sdo_oe !== 1'b0 || sdi_oe !== 1'b0) begin
            oe_err++;
         end
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      cs_n = 1'b1;
      sdi  = 1'b0;
      repeat (4 * HALF) @(negedge clk);
      if (!rw) begin
         for (int j = 0; j < nbytes; j++) begin
            logic [5:0] a;
            a = step_addr(addr, inc, j);
            if (8 * (j + 2) <= total && a != 6'h0F) model[a] = wbuf[j];
         end
      end
   endtask

   task automatic rd1(input logic [5:0] a, input string req);
      xfer(1'b1, 1'b0, a, 1, 0);
      chk(req, 32'(rbuf[0]), 32'(model[a]), $sformatf("read of %0h", a));
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
      for (int i = 0; i < 64; i++) model[i] = 8'h00;
      model[15] = 8'h33;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9: enables low out of reset
      chk("R9", 32'(sdo_oe), 0, "sdo_oe after reset");
      chk("R9", 32'(sdi_oe), 0, "sdi_oe after reset");

      // R9 / R5: reset contents of every register, R1 addressing
      for (int a = 0; a < 64; a++) begin
         rd1(6'(a), (a == 15) ? "R5" : "R9");
         chk("R6", 32'(oe_err), 0, "enable pattern on read");
      end

      // R2: write every register (bit 0 cleared so the mode stays 4-wire)
      for (int a = 0; a < 64; a++) begin
         wbuf[0] = 8'(a * 37 + 11) & 8'hFE;
         xfer(1'b0, 1'b0, 6'(a), 1, 0);
         chk("R6", 32'(oe_err), 0, "enables during write");
      end
      for (int a = 0; a < 64; a++) rd1(6'(a), (a == 15) ? "R5" : "R2");

      // R3: stepping write across the wrap 3Dh..00h
      wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA4; wbuf[3] = 8'hA8;
      xfer(1'b0, 1'b1, 6'h3D, 4, 0);
      rd1(6'h3D, "R3"); rd1(6'h3E, "R3"); rd1(6'h3F, "R3"); rd1(6'h00, "R3");
      xfer(1'b1, 1'b1, 6'h3E, 3, 0);
      chk("R3", 32'(rbuf[0]), 32'(model[6'h3E]), "stepped read byte 0");
      chk("R3", 32'(rbuf[1]), 32'(model[6'h3F]), "stepped read byte 1");
      chk("R3", 32'(rbuf[2]), 32'(model[6'h00]), "stepped read wrapped byte");

      // R5: stepping write through the identity register
      wbuf[0] = 8'h5C; wbuf[1] = 8'h77; wbuf[2] = 8'h9E;
      xfer(1'b0, 1'b1, 6'h0E, 3, 0);
      rd1(6'h0E, "R3"); rd1(6'h0F, "R5"); rd1(6'h10, "R3");

      // R4: fixed-address burst
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h3C;
      xfer(1'b0, 1'b0, 6'h12, 3, 0);
      rd1(6'h12, "R4"); rd1(6'h13, "R4"); rd1(6'h14, "R4");
      xfer(1'b1, 1'b0, 6'h12, 3, 0);
      for (int j = 0; j < 3; j++)
         chk("R4", 32'(rbuf[j]), 32'h3C, "repeated read byte");

      // R8: abort inside a data byte and inside a command
      wbuf[0] = 8'hC3;
      xfer(1'b0, 1'b0, 6'h20, 1, 12);
      rd1(6'h20, "R8");
      xfer(1'b1, 1'b0, 6'h21, 1, 5);
      chk("R8", 32'(sdo_oe | sdi_oe), 0, "enables after aborted command");
      wbuf[0] = 8'h6E;
      xfer(1'b0, 1'b0, 6'h21, 1, 0);
      rd1(6'h21, "R8");

      // R7: switch to 3-wire and read back on the shared pin
      wbuf[0] = 8'h01;
      xfer(1'b0, 1'b0, 6'h23, 1, 0);
      for (int a = 32; a < 40; a++) begin
         rd1(6'(a), "R7");
         chk("R7", 32'(oe_err), 0, "shared-pin enable pattern");
      end
      xfer(1'b1, 1'b1, 6'h3F, 2, 0);
      chk("R7", 32'(rbuf[0]), 32'(model[6'h3F]), "3-wire stepped byte 0");
      chk("R3", 32'(rbuf[1]), 32'(model[6'h00]), "3-wire wrapped byte 1");
      wbuf[0] = 8'h00;
      xfer(1'b0, 1'b0, 6'h23, 1, 0);
      rd1(6'h23, "R7");
      chk("R7", 32'(oe_err), 0, "back to dedicated pin");

      // R6: idle enables after all traffic
      chk("R6", 32'(sdo_oe | sdi_oe), 0, "enables with chip select high");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule